// File: doc/BRIEF.md
# Three-Phase Disturbance Reference Generator

This block produces three balanced sinusoidal voltage references for a test voltage source that imitates a supply grid. A single phase accumulator advances by a frequency tuning word each clock. The second and third phases are taken from it at one third and two thirds of a turn ahead. Each phase value addresses a quarter-wave-folded sine table. The signed sample is then scaled by a magnitude gain and a soft-start ramp gain, and saturated.

Two parameter sets are held at the ports: a nominal set and a disturbance set, each with a tuning word, a magnitude and a starting phase. A sequencer drives the set select. Raising it loads the disturbance starting phase and switches to the disturbance tuning word and magnitude, which produces a phase jump, a frequency deviation and a sag or swell. Lowering it loads the nominal re-entry phase and restores nominal frequency and magnitude. For the sequencer, the block reports the angle of a chosen reference phase and a one-clock pulse whenever that phase passes through a full turn. The sequencer uses these to time the start and the end of a disturbance against a chosen point on the waveform.

Top module: `tri_phase_ref_gen`

## Requirements
- R1: While reset is held, all three samples read 0, the cycle-wrap pulse is low, and the reference angle reads 0 when phase A is the reference.
- R2: The phase A sample equals round(32767 * sin(2*pi*(k + 0.5)/1024)) scaled by the gain. Here k is bits 31:22 of the accumulator, so the sample sits at the centre of the addressed 1/1024-turn bin. The sample appears two clock edges after the accumulator edge, within 48 + gain/512 LSB of that value.
- R3: Phase B uses the accumulator plus 0x5555_5555 and phase C the accumulator plus 0xAAAA_AAAB. Both follow the R2 rule, so the three samples sum to nearly zero.
- R4: When the set select is unchanged from the previous edge, the accumulator grows by the nominal tuning word if select is 0 and by the disturbance tuning word if select is 1, modulo 2^32.
- R5: On an edge where select rises, the accumulator is loaded with the disturbance starting phase. On an edge where it falls, it is loaded with the nominal re-entry phase. No increment is applied on either edge.
- R6: The gain is (magnitude * ramp) >> 16. The magnitude is the disturbance one when select was 1 at the accumulator edge and the nominal one otherwise. The sample is (sine * gain) >>> 15, so a magnitude of 0x8000 with a full ramp is close to unity, smaller gives a sag and larger a swell.
- R7: Scaled samples saturate to the range -32768..32767 and never wrap in sign.
- R8: The reference angle output is bits 31:16 of the selected phase: select code 0 or 3 picks A, 1 picks B and 2 picks C. It reflects the accumulator in the same cycle.
- R9: The cycle-wrap pulse is high for exactly one clock after an incrementing edge on which the selected phase passed 2^32. It is never high after a phase-load edge.
- R10: A ramp input of 0 forces all three samples to 0 two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_sel_i | input | 1 | 1 selects the disturbance set, 0 the nominal set |
| nom_ftw_i | input | 32 | Nominal frequency tuning word |
| dis_ftw_i | input | 32 | Disturbance frequency tuning word |
| nom_phase_i | input | 32 | Phase loaded when the disturbance ends |
| dis_phase_i | input | 32 | Phase loaded when the disturbance starts |
| nom_mag_i | input | 16 | Nominal magnitude gain, 0x8000 near unity |
| dis_mag_i | input | 16 | Disturbance magnitude gain |
| ramp_i | input | 16 | Soft-start ramp gain, 0xFFFF near full |
| ref_sel_i | input | 2 | Reference phase: 0/3 A, 1 B, 2 C |
| ph_a_o | output | 16 | Signed phase A sample |
| ph_b_o | output | 16 | Signed phase B sample |
| ph_c_o | output | 16 | Signed phase C sample |
| ref_angle_o | output | 16 | Upper bits of the reference phase angle |
| cycle_wrap_o | output | 1 | One-clock pulse when the reference phase completes a turn |

## Verification
The reference angle and the wrap pulse belong to the accumulator edge itself. They are compared on the falling edge that follows. The samples trail that edge by two more registers, the table read and the scaling stage. For this reason the bench keeps a three-deep history of its own accumulator and magnitude model and a two-deep history of the ramp input, and checks each sample against the entry from two edges earlier. Phase loads and saturation are checked exactly with the tuning word held at zero. The remaining samples are compared within a tolerance taken from the table's approximation error.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int unsigned PHASES = 3;

    // Fraction num/3 of a full accumulator turn, rounded.
    function automatic longint unsigned turn_part(longint unsigned num, int unsigned acc_w);
        return (((64'd1) << acc_w) * num + 64'd1) / 64'd3;
    endfunction

    // Quarter-wave table entry i of qd, taken at the bin centre and computed
    // with a rational sine approximation in integer arithmetic.
    function automatic longint unsigned quarter_sine(longint unsigned i, longint unsigned qd,
                                                     longint unsigned amp);
        longint unsigned h, a, p, num, den;
        h   = 64'd4 * qd;
        a   = 64'd2 * i + 64'd1;
        p   = a * (h - a);
        num = amp * 64'd16 * p;
        den = 64'd5 * h * h - 64'd4 * p;
        return (num + den / 64'd2) / den;
    endfunction

endpackage

// File: rtl/tpr_phase_acc.sv
module tpr_phase_acc #(
    parameter int ACC_W  = 32,
    parameter int GAIN_W = 16,
    parameter int ANG_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic [ACC_W-1:0]  nom_ftw_i,
    input  logic [ACC_W-1:0]  dis_ftw_i,
    input  logic [ACC_W-1:0]  nom_ph_i,
    input  logic [ACC_W-1:0]  dis_ph_i,
    input  logic [GAIN_W-1:0] nom_mag_i,
    input  logic [GAIN_W-1:0] dis_mag_i,
    input  logic [1:0]        ref_sel_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [GAIN_W-1:0] mag_o,
    output logic [ANG_W-1:0]  ref_ang_o,
    output logic              wrap_o
);

    localparam logic [ACC_W-1:0] OFF_B = ACC_W'(tpr_pkg::turn_part(64'd1, ACC_W));
    localparam logic [ACC_W-1:0] OFF_C = ACC_W'(tpr_pkg::turn_part(64'd2, ACC_W));

    typedef struct packed {
        logic              sel;
        logic [ACC_W-1:0]  acc;
        logic [GAIN_W-1:0] mag;
        logic              wrap;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] ref_off;
    logic [ACC_W-1:0] ref_now;
    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   ref_sum;

    always_comb begin
        case (ref_sel_i)
            2'd1:    ref_off = OFF_B;
            2'd2:    ref_off = OFF_C;
            default: ref_off = '0;
        endcase
        ref_now = st_q.acc + ref_off;
        step    = sel_i ? dis_ftw_i : nom_ftw_i;
        ref_sum = {1'b0, ref_now} + {1'b0, step};

        st_d     = st_q;
        st_d.sel = sel_i;
        st_d.mag = sel_i ? dis_mag_i : nom_mag_i;
        if (sel_i != st_q.sel) begin
            // entering or leaving the disturbance: load the programmed phase
            st_d.acc  = sel_i ? dis_ph_i : nom_ph_i;
            st_d.wrap = 1'b0;
        end else begin
            st_d.acc  = st_q.acc + step;
            st_d.wrap = ref_sum[ACC_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign acc_o     = st_q.acc;
    assign mag_o     = st_q.mag;
    assign wrap_o    = st_q.wrap;
    assign ref_ang_o = ref_now[ACC_W-1 -: ANG_W];

    assert_no_wrap_on_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i != st_q.sel) |=> !wrap_o)
        else $error("wrap pulse after a phase load");

    assert_wrap_means_turn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_o && $stable(ref_sel_i)) |-> (ref_now < $past(ref_now)))
        else $error("wrap pulse without a full turn");

    assert_enter_loads_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !st_q.sel) |=> (acc_o == $past(dis_ph_i)))
        else $error("disturbance phase not loaded");

    assert_exit_loads_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sel_i && st_q.sel) |=> (acc_o == $past(nom_ph_i)))
        else $error("nominal phase not loaded");

endmodule

// File: rtl/tpr_gain.sv
module tpr_gain #(
    parameter int GAIN_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [GAIN_W-1:0] mag_i,
    input  logic [GAIN_W-1:0] ramp_i,
    output logic [GAIN_W-1:0] gain_o
);

    localparam int PROD_W = 2 * GAIN_W;

    logic [PROD_W-1:0] prod;
    logic [GAIN_W-1:0] gain_d, gain_q;

    always_comb begin
        prod   = PROD_W'(mag_i) * PROD_W'(ramp_i);
        gain_d = prod[PROD_W-1 -: GAIN_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gain_q <= '0;
        else         gain_q <= gain_d;
    end

    assign gain_o = gain_q;

    assert_ramp_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ramp_i == '0) |=> (gain_o == '0))
        else $error("zero ramp gave nonzero gain");

endmodule

// File: rtl/tpr_sine_lut.sv
module tpr_sine_lut #(
    parameter int ACC_W  = 32,
    parameter int LUT_AW = 10,
    parameter int SAMP_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ACC_W-1:0]         phase_i,
    output logic signed [SAMP_W-1:0] sample_o
);

    localparam int QAW = LUT_AW - 2;
    localparam int QD  = 1 << QAW;
    localparam int AMP = (1 << (SAMP_W - 1)) - 1;

    logic [SAMP_W-2:0] qtab [QD];

    for (genvar gi = 0; gi < QD; gi++) begin : g_tab
        assign qtab[gi] = (SAMP_W-1)'(tpr_pkg::quarter_sine(64'(gi), 64'(QD), 64'(AMP)));
    end

    logic [LUT_AW-1:0]         addr;
    logic [QAW-1:0]            idx;
    logic [SAMP_W-2:0]         amp_sel;
    logic signed [SAMP_W-1:0]  samp_d, samp_q;

    always_comb begin
        addr    = phase_i[ACC_W-1 -: LUT_AW];
        idx     = addr[QAW-1:0];
        if (addr[QAW]) idx = ~idx;          // second and fourth quarter run backwards
        amp_sel = qtab[idx];
        samp_d  = addr[LUT_AW-1] ? -$signed({1'b0, amp_sel}) : $signed({1'b0, amp_sel});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) samp_q <= '0;
        else         samp_q <= samp_d;
    end

    assign sample_o = samp_q;

    assert_upper_half_nonneg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_i[ACC_W-1] |=> !sample_o[SAMP_W-1])
        else $error("negative sample in first half turn");

    assert_lower_half_nonpos_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_i[ACC_W-1] |=> (sample_o[SAMP_W-1] || (sample_o == '0)))
        else $error("positive sample in second half turn");

endmodule

// File: rtl/tpr_scaler.sv
module tpr_scaler #(
    parameter int SAMP_W = 16,
    parameter int GAIN_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic signed [SAMP_W-1:0] sample_i,
    input  logic [GAIN_W-1:0]        gain_i,
    output logic signed [SAMP_W-1:0] out_o
);

    localparam int PROD_W = SAMP_W + GAIN_W + 1;
    localparam int SHIFT  = GAIN_W - 1;
    localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [SAMP_W-1:0] out_d, out_q;

    always_comb begin
        prod    = $signed(PROD_W'(sample_i)) * $signed(PROD_W'({1'b0, gain_i}));
        shifted = prod >>> SHIFT;
        if (shifted > MAXV)      out_d = MAXV[SAMP_W-1:0];
        else if (shifted < MINV) out_d = MINV[SAMP_W-1:0];
        else                     out_d = shifted[SAMP_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign out_o = out_q;

    assert_zero_gain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gain_i == '0) |=> (out_o == '0))
        else $error("zero gain gave nonzero output");

    assert_sign_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sample_i[SAMP_W-1]) |=> !out_o[SAMP_W-1])
        else $error("scaled sample wrapped sign");

endmodule

// File: rtl/tri_phase_ref_gen.sv
module tri_phase_ref_gen #(
    parameter int ACC_W  = 32,
    parameter int LUT_AW = 10,
    parameter int SAMP_W = 16,
    parameter int GAIN_W = 16,
    parameter int ANG_W  = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     dist_sel_i,
    input  logic [ACC_W-1:0]         nom_ftw_i,
    input  logic [ACC_W-1:0]         dis_ftw_i,
    input  logic [ACC_W-1:0]         nom_phase_i,
    input  logic [ACC_W-1:0]         dis_phase_i,
    input  logic [GAIN_W-1:0]        nom_mag_i,
    input  logic [GAIN_W-1:0]        dis_mag_i,
    input  logic [GAIN_W-1:0]        ramp_i,
    input  logic [1:0]               ref_sel_i,
    output logic signed [SAMP_W-1:0] ph_a_o,
    output logic signed [SAMP_W-1:0] ph_b_o,
    output logic signed [SAMP_W-1:0] ph_c_o,
    output logic [ANG_W-1:0]         ref_angle_o,
    output logic                     cycle_wrap_o
);

    localparam int NPH = tpr_pkg::PHASES;

    logic [ACC_W-1:0]         acc;
    logic [GAIN_W-1:0]        mag_act;
    logic [GAIN_W-1:0]        gain;
    logic [ACC_W-1:0]         phase [NPH];
    logic signed [SAMP_W-1:0] raw   [NPH];
    logic signed [SAMP_W-1:0] outs  [NPH];

    tpr_phase_acc #(.ACC_W(ACC_W), .GAIN_W(GAIN_W), .ANG_W(ANG_W)) u_acc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (dist_sel_i),
        .nom_ftw_i (nom_ftw_i),
        .dis_ftw_i (dis_ftw_i),
        .nom_ph_i  (nom_phase_i),
        .dis_ph_i  (dis_phase_i),
        .nom_mag_i (nom_mag_i),
        .dis_mag_i (dis_mag_i),
        .ref_sel_i (ref_sel_i),
        .acc_o     (acc),
        .mag_o     (mag_act),
        .ref_ang_o (ref_angle_o),
        .wrap_o    (cycle_wrap_o)
    );

    tpr_gain #(.GAIN_W(GAIN_W)) u_gain (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mag_i  (mag_act),
        .ramp_i (ramp_i),
        .gain_o (gain)
    );

    for (genvar gp = 0; gp < NPH; gp++) begin : g_phase
        localparam logic [ACC_W-1:0] OFF = ACC_W'(tpr_pkg::turn_part(64'(gp), ACC_W));

        assign phase[gp] = acc + OFF;

        tpr_sine_lut #(.ACC_W(ACC_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_lut (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .phase_i  (phase[gp]),
            .sample_o (raw[gp])
        );

        tpr_scaler #(.SAMP_W(SAMP_W), .GAIN_W(GAIN_W)) u_scale (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sample_i (raw[gp]),
            .gain_i   (gain),
            .out_o    (outs[gp])
        );
    end

    assign ph_a_o = outs[0];
    assign ph_b_o = outs[1];
    assign ph_c_o = outs[2];

endmodule

// File: tb/tri_phase_ref_gen_bench.sv
`timescale 1ns/1ps
module tri_phase_ref_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dist_sel = 1'b0;
    logic [31:0] nom_ftw = '0, dis_ftw = '0, nom_phase = '0, dis_phase = '0;
    logic [15:0] nom_mag = '0, dis_mag = '0, ramp = '0;
    logic [1:0]  ref_sel = '0;
    logic signed [15:0] ph_a, ph_b, ph_c;
    logic [15:0] ref_angle;
    logic        wrap;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    tri_phase_ref_gen u_tri_phase_ref_gen (
        .clk_i(clk), .rst_ni(rst_n), .dist_sel_i(dist_sel),
        .nom_ftw_i(nom_ftw), .dis_ftw_i(dis_ftw),
        .nom_phase_i(nom_phase), .dis_phase_i(dis_phase),
        .nom_mag_i(nom_mag), .dis_mag_i(dis_mag), .ramp_i(ramp),
        .ref_sel_i(ref_sel), .ph_a_o(ph_a), .ph_b_o(ph_b), .ph_c_o(ph_c),
        .ref_angle_o(ref_angle), .cycle_wrap_o(wrap)
    );

    // bench model state
    bit [31:0]   m_acc = '0;
    bit          m_sel = 1'b0;
    bit          m_wrap = 1'b0;
    bit [31:0]   a_h [3] = '{default: '0};
    longint      mag_h [3] = '{default: 0};
    longint      ramp_h [2] = '{default: 0};

    function automatic bit [31:0] off_of(input logic [1:0] s, input int p);
        int k;
        k = (p >= 0) ? p : ((s == 2'd1) ? 1 : (s == 2'd2) ? 2 : 0);
        return (k == 1) ? 32'h5555_5555 : (k == 2) ? 32'hAAAA_AAAB : 32'h0;
    endfunction

    function automatic int exp_sample(input bit [31:0] ph, input longint g);
        real ang, v;
        int  r;
        ang = 2.0 * 3.14159265358979 * (real'(ph[31:22]) + 0.5) / 1024.0;
        v   = 32767.0 * $sin(ang) * real'(g) / 32768.0;
        r   = $rtoi((v >= 0.0) ? v + 0.5 : v - 0.5);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic ck_eq(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic ck_tol(input string req, input string what, input int act, input int expv, input int tol);
        checks++;
        if (act > expv + tol || act < expv - tol) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (tol %0d)", req, what, act, expv, tol);
        end
    endtask

    task automatic model_edge();
        bit [31:0] old_r, new_r;
        if (dist_sel != m_sel) begin
            m_acc  = dist_sel ? dis_phase : nom_phase;
            m_wrap = 1'b0;
        end else begin
            old_r  = m_acc + off_of(ref_sel, -1);
            m_acc  = m_acc + (dist_sel ? dis_ftw : nom_ftw);
            new_r  = m_acc + off_of(ref_sel, -1);
            m_wrap = (new_r < old_r);
        end
        m_sel = dist_sel;
        a_h[2] = a_h[1]; a_h[1] = a_h[0]; a_h[0] = m_acc;
        mag_h[2] = mag_h[1]; mag_h[1] = mag_h[0];
        mag_h[0] = dist_sel ? longint'(dis_mag) : longint'(nom_mag);
        ramp_h[1] = ramp_h[0]; ramp_h[0] = longint'(ramp);
    endtask

    task automatic check_outputs();
        bit [31:0] ra;
        longint    g;
        int        tol;
        ra  = m_acc + off_of(ref_sel, -1);
        ck_eq("R8", "reference angle", ref_angle, ra[31:16]);
        ck_eq("R9", "wrap pulse", wrap, m_wrap);
        g   = (mag_h[2] * ramp_h[1]) >>> 16;
        tol = 48 + int'(g / 512);
        ck_tol("R2", "phase A sample", ph_a, exp_sample(a_h[2] + off_of(ref_sel, 0), g), tol);
        ck_tol("R3", "phase B sample", ph_b, exp_sample(a_h[2] + off_of(ref_sel, 1), g), tol);
        ck_tol("R3", "phase C sample", ph_c, exp_sample(a_h[2] + off_of(ref_sel, 2), g), tol);
    endtask

    task automatic step(input bit chk);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (chk) check_outputs();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        int nwrap;
        void'($urandom(32'd20240611));
        nom_ftw = 32'h0100_0000; nom_mag = 16'h8000; ramp = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        ck_eq("R1", "phase A in reset", ph_a, 0);
        ck_eq("R1", "phase B in reset", ph_b, 0);
        ck_eq("R1", "phase C in reset", ph_c, 0);
        ck_eq("R1", "wrap in reset", wrap, 0);
        ck_eq("R1", "angle in reset", ref_angle, 0);
        rst_n = 1'b1;

        // nominal running, phase A reference: R2, R8, R9
        nwrap = 0;
        for (int i = 0; i < 512; i++) begin
            step(1'b1);
            if (wrap) nwrap++;
        end
        ck_eq("R9", "wraps in two turns", nwrap, 2);
        ck_tol("R3", "three-phase sum", int'(ph_a) + int'(ph_b) + int'(ph_c), 0, 200);
        ref_sel = 2'd1;
        for (int i = 0; i < 100; i++) step(1'b1);
        ref_sel = 2'd2;
        for (int i = 0; i < 100; i++) step(1'b1);
        ref_sel = 2'd3;
        for (int i = 0; i < 40; i++) step(1'b1);
        ref_sel = 2'd0;

        // R5 / R4: phase loads and tuning-word selection
        dis_phase = 32'h4000_0000; dis_ftw = 32'h0002_0000; dist_sel = 1'b1;
        step(1'b1);
        ck_eq("R5", "angle after entry load", ref_angle, 16'h4000);
        ck_eq("R9", "no wrap on entry load", wrap, 0);
        repeat (3) step(1'b1);
        ck_eq("R4", "angle after three disturbance steps", ref_angle, 16'h4006);
        nom_phase = 32'hC000_0000; dist_sel = 1'b0;
        step(1'b1);
        ck_eq("R5", "angle after exit load", ref_angle, 16'hC000);
        step(1'b1);
        ck_eq("R4", "angle after one nominal step", ref_angle, 16'hC100);

        // R6: sag at a frozen peak
        dis_mag = 16'h4000; dis_ftw = '0; dis_phase = 32'h4000_0000; dist_sel = 1'b1;
        repeat (3) step(1'b1);
        ck_tol("R6", "sag peak", ph_a, 16383, 80);

        // R7: swell saturating both ways
        nom_mag = 16'hFFFF; nom_ftw = '0; nom_phase = 32'h4000_0000; dist_sel = 1'b0;
        repeat (3) step(1'b1);
        ck_eq("R7", "positive clamp", ph_a, 32767);
        dist_sel = 1'b1; step(1'b1);
        nom_phase = 32'hC000_0000; dist_sel = 1'b0;
        repeat (3) step(1'b1);
        ck_eq("R7", "negative clamp", ph_a, -32768);

        // R10: ramp at zero
        ramp = '0;
        repeat (2) step(1'b1);
        ck_eq("R10", "phase A with zero ramp", ph_a, 0);
        ck_eq("R10", "phase B with zero ramp", ph_b, 0);
        ck_eq("R10", "phase C with zero ramp", ph_c, 0);
        ramp = 16'hFFFF;
        nom_mag = 16'h8000;

        // constrained random mix
        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 15) == 0) nom_ftw = $urandom() >> $urandom_range(2, 10);
            if ($urandom_range(0, 15) == 0) dis_ftw = $urandom() >> $urandom_range(2, 10);
            if ($urandom_range(0, 7) == 0) begin
                nom_phase = $urandom(); dis_phase = $urandom();
                nom_mag = 16'($urandom()); dis_mag = 16'($urandom());
            end
            if ($urandom_range(0, 19) == 0) dist_sel = ~dist_sel;
            if ($urandom_range(0, 29) == 0) ref_sel = 2'($urandom());
            if ($urandom_range(0, 39) == 0) ramp = 16'($urandom());
            step(1'b1);
        end

        finish_run();
    end

endmodule